// File: doc/BRIEF.md
# Enable-Gated I2C Register Target

This block is a Standard-mode I2C target that lets a host reach a byte-wide register space. It samples SCL and SDA with the system clock and pulls SDA low through an open-drain enable. A register file beside it sees a register pointer, a one-cycle write strobe with write data, and returns read data for the current pointer. An active-low enable input decides whether the block takes part in bus traffic at all. Several copies can therefore share one bus with the same fixed address, and the host selects one copy at a time.

A write sends the address byte with R/W clear, then a pointer byte, then one data byte. If the host issues STOP after the pointer byte, the transfer only sets the pointer. A read sends the address byte with R/W set, either after a pointer set or after a repeated START, and the block returns the register at the stored pointer. Both bus lines pass through a synchroniser and a glitch filter. SDA changes only after a hold delay that follows each SCL falling edge. A watchdog returns the interface to idle if SCL, or SDA driven by the block, stays low too long.

Top module: `i2c_enreg_target`

## Requirements
- R1: After reset, sda_oe and reg_wr_stb are 0 and reg_ptr is 0x00.
- R2: An address byte whose upper seven bits equal 0x48 is acknowledged in the ninth clock. Any other address is not acknowledged, and the block drives SDA for none of the bytes that follow until the next START.
- R3: While en_n is high, the block never drives SDA, acknowledges nothing and writes nothing.
- R4: In a write, the first byte after the address (R/W=0) becomes reg_ptr and is acknowledged. The second byte is acknowledged and issued as a single-cycle reg_wr_stb with that byte on reg_wr_data. Bytes after that get no acknowledge and cause no write.
- R5: A STOP after the pointer byte keeps the pointer. A later read (address byte with R/W=1) shifts out reg_rd_data for that pointer, MSB first.
- R6: A repeated START after the pointer byte, followed by a read address, returns the register at the new pointer.
- R7: A host NACK in the ninth clock of a read byte ends the read. SDA stays released on every following clock until the next START.
- R8: A START or STOP that arrives part-way through a data byte abandons that byte, and no write happens.
- R9: If SCL stays low, or the block holds SDA low, for TMO_CYC clock cycles, the block releases SDA and returns to idle. A later transaction then works normally.
- R10: A pulse on SDA shorter than FILT_CYC clock cycles is not seen as a bus event.
- R11: Each change the block makes to SDA comes at least HOLD_CYC clock cycles after the SCL falling edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low bus participation enable |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_ptr | output | 8 | Current register pointer |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_data | input | 8 | Register contents at reg_ptr |

## Verification
Directed transfers cover each case on its own:
- a full write;
- a pointer set followed by a read;
- a read after a repeated START;
- a foreign address;
- a transfer while disabled;
- a NACK-terminated read;
- a STOP and a START placed mid-byte;
- a short SDA glitch inside an address bit;
- SCL parked low during an acknowledge.

These runs show whether the pointer and data paths are kept apart, whether gating and address matching suppress all driving, and whether aborts discard partial bytes. Random writes, pointer-set reads and repeated-START reads to random pointers with random data follow. They are checked against a bench model of the register space, so stale pointers and bit-order errors are caught.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_WDAT, PH_RDAT, PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2ct_line_cond.sv
`timescale 1ns/1ps
module i2ct_line_cond #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic line_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_i};
  end

  generate
    if (FILT_CYC <= 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_o <= 1'b1;
        else        line_o <= sync_q[1];
      end
    end else begin : g_filt
      localparam int CW = $clog2(FILT_CYC + 1);
      logic [CW-1:0] run_q, run_d;
      logic          line_d;

      always_comb begin
        run_d  = '0;
        line_d = line_o;
        if (sync_q[1] != line_o) begin
          if (run_q == CW'(FILT_CYC - 1)) line_d = sync_q[1];
          else                            run_d  = run_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q  <= '0;
          line_o <= 1'b1;
        end else begin
          run_q  <= run_d;
          line_o <= line_d;
        end
      end

      // R10
      glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(sync_q[1]) == line_o && $past(run_q) == CW'(FILT_CYC - 1)));
    end
  endgenerate
endmodule

// File: rtl/i2ct_watchdog.sv
`timescale 1ns/1ps
module i2ct_watchdog #(
  parameter int TMO_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_i,
  output logic fire_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_d;

  always_comb begin
    cnt_d  = '0;
    fire_d = 1'b0;
    if (stall_i) begin
      if (cnt_q == CW'(TMO_CYC - 1)) fire_d = 1'b1;
      else                           cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_o <= fire_d;
    end
  end

  // R9
  fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(stall_i));
  // R9
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/i2ct_hold_drv.sv
`timescale 1ns/1ps
module i2ct_hold_drv #(
  parameter int HOLD_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic load_i,
  input  logic val_i,
  output logic oe_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d, oe_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    oe_d   = oe_o;
    if (clr_i) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (load_i) begin
      cnt_d  = CW'(HOLD_CYC);
      pend_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) oe_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      oe_o   <= oe_d;
    end
  end

  // R11
  hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_o != $past(oe_o)) && !$past(clr_i)) |-> ($past(cnt_q) == CW'(1)));
endmodule

// File: rtl/i2c_enreg_target.sv
`timescale 1ns/1ps
module i2c_enreg_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int         FILT_CYC    = 10,
  parameter int         HOLD_CYC    = 64,
  parameter int         TMO_CYC     = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic              reg_wr_stb,
  output logic [BYTE_W-1:0] reg_wr_data,
  input  logic [BYTE_W-1:0] reg_rd_data
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
  localparam logic [3:0] ACK_DONE = 4'(BYTE_W + 1);

  logic [1:0] rst_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  logic scl_f, sda_f;
  i2ct_line_cond #(.FILT_CYC(FILT_CYC)) scl_cond_i (.clk(clk), .rst_n(rst_sn), .pin_i(scl_i), .line_o(scl_f));
  i2ct_line_cond #(.FILT_CYC(FILT_CYC)) sda_cond_i (.clk(clk), .rst_n(rst_sn), .pin_i(sda_i), .line_o(sda_f));

  logic tmo;
  i2ct_watchdog #(.TMO_CYC(TMO_CYC)) wdog_i (.clk(clk), .rst_n(rst_sn), .stall_i(~scl_f | sda_oe), .fire_o(tmo));

  logic drv_clr, drv_load, drv_val;
  i2ct_hold_drv #(.HOLD_CYC(HOLD_CYC)) drv_i (.clk(clk), .rst_n(rst_sn), .clr_i(drv_clr),
    .load_i(drv_load), .val_i(drv_val), .oe_o(sda_oe));

  phase_e            ph_q, ph_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d, ptr_q, ptr_d, wdat_q, wdat_d;
  logic              rd_q, rd_d, nack_q, nack_d, wstb_q, wstb_d;
  logic              scl_p, sda_p;
  logic [1:0]        en_q;
  logic              scl_rise, scl_fall, start_evt, stop_evt, active;

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_evt = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
  assign active    = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);

  always_comb begin
    ph_d = ph_q;  cnt_d = cnt_q;  rx_d = rx_q;  tx_d = tx_q;
    ptr_d = ptr_q;  wdat_d = wdat_q;  rd_d = rd_q;  nack_d = nack_q;
    wstb_d = 1'b0;  drv_clr = 1'b0;  drv_load = 1'b0;  drv_val = 1'b0;
    if (en_q[1] || tmo) begin
      ph_d = PH_IDLE;  cnt_d = '0;  drv_clr = 1'b1;
    end else if (start_evt) begin
      ph_d = PH_ADDR;  cnt_d = '0;  drv_clr = 1'b1;
    end else if (stop_evt) begin
      ph_d = PH_IDLE;  cnt_d = '0;  drv_clr = 1'b1;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt_q < LAST_BIT) begin
          rx_d  = {rx_q[BYTE_W-2:0], sda_f};
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == LAST_BIT) begin
          nack_d = sda_f;
          cnt_d  = ACK_DONE;
        end
      end else if (scl_fall) begin
        drv_load = 1'b1;
        if (cnt_q == LAST_BIT) begin
          unique case (ph_q)
            PH_ADDR: if (rx_q[7:1] == TARGET_ADDR) begin
                       drv_val = 1'b1;  rd_d = rx_q[0];
                     end else ph_d = PH_SKIP;
            PH_PTR:  begin ptr_d = rx_q;  drv_val = 1'b1; end
            PH_WDAT: begin wstb_d = 1'b1;  wdat_d = rx_q;  drv_val = 1'b1; end
            default: drv_val = 1'b0;
          endcase
        end else if (cnt_q == ACK_DONE) begin
          cnt_d = '0;
          unique case (ph_q)
            PH_ADDR: if (rd_q) begin
                       ph_d = PH_RDAT;  tx_d = reg_rd_data;  drv_val = ~reg_rd_data[7];
                     end else ph_d = PH_PTR;
            PH_PTR:  ph_d = PH_WDAT;
            PH_RDAT: if (nack_q) ph_d = PH_SKIP;
                     else begin tx_d = reg_rd_data;  drv_val = ~reg_rd_data[7]; end
            default: ph_d = PH_SKIP;
          endcase
        end else if (ph_q == PH_RDAT) begin
          drv_val = ~tx_q[3'd7 - cnt_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q <= PH_IDLE;  cnt_q <= '0;  rx_q <= '0;  tx_q <= '0;
      ptr_q <= '0;  wdat_q <= '0;  rd_q <= 1'b0;  nack_q <= 1'b0;
      wstb_q <= 1'b0;  scl_p <= 1'b1;  sda_p <= 1'b1;  en_q <= 2'b11;
    end else begin
      ph_q <= ph_d;  cnt_q <= cnt_d;  rx_q <= rx_d;  tx_q <= tx_d;
      ptr_q <= ptr_d;  wdat_q <= wdat_d;  rd_q <= rd_d;  nack_q <= nack_d;
      wstb_q <= wstb_d;  scl_p <= scl_f;  sda_p <= sda_f;  en_q <= {en_q[0], en_n};
    end
  end

  assign reg_ptr     = ptr_q;
  assign reg_wr_stb  = wstb_q;
  assign reg_wr_data = wdat_q;

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    en_q[1] |=> !sda_oe);
  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_wr_stb |=> !reg_wr_stb);
  // R11
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sda_oe) |-> !scl_f);
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_evt |=> (!sda_oe && ph_q == PH_IDLE));
  // R9
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    tmo |=> (!sda_oe && ph_q == PH_IDLE));
endmodule

// File: tb/i2c_enreg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_enreg_target_tb_top;
  localparam int FILT = 3, HOLD = 16, TMO = 3000, HP = 50, QT = 30;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en_n, scl_h, sda_h;
  logic sda_oe, reg_wr_stb;
  logic [7:0] reg_ptr, reg_wr_data, reg_rd_data;
  logic sda_line;
  logic [7:0] dev_mem [256];
  logic [7:0] exp_mem [256];

  assign sda_line    = sda_h & ~sda_oe;
  assign reg_rd_data = dev_mem[reg_ptr];

  i2c_enreg_target #(.TARGET_ADDR(7'h48), .FILT_CYC(FILT), .HOLD_CYC(HOLD), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_ptr(reg_ptr), .reg_wr_stb(reg_wr_stb),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data));

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5C;
  endfunction

  int nchk = 0, nfail = 0;
  int wr_cnt = 0, oe_cnt = 0, gap = 0, last_gap = 0;
  logic [7:0] last_wr_ptr, last_wr_data;
  logic scl_hp, oe_p;
  bit glitch_next = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dev_mem[i] <= init_val(i[7:0]);
    end else if (reg_wr_stb) begin
      dev_mem[reg_ptr] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
      last_wr_ptr <= reg_ptr;
      last_wr_data <= reg_wr_data;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    scl_hp <= scl_h;
    oe_p   <= sda_oe;
    if (scl_hp && !scl_h) gap <= 1; else gap <= gap + 1;
    if (sda_oe && !oe_p) last_gap <= gap;
  end

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_start();
    wcyc(QT); sda_h = 1'b1;
    wcyc(HP - QT); scl_h = 1'b1;
    wcyc(HP); sda_h = 1'b0;
    wcyc(HP); scl_h = 1'b0;
  endtask

  task automatic t_stop();
    wcyc(QT); sda_h = 1'b0;
    wcyc(HP - QT); scl_h = 1'b1;
    wcyc(HP); sda_h = 1'b1;
    wcyc(HP);
  endtask

  task automatic t_bit(input logic b, output logic rb);
    wcyc(QT); sda_h = b;
    wcyc(HP - QT); scl_h = 1'b1;
    if (glitch_next && b) begin
      wcyc(HP / 4); sda_h = 1'b0;
      wcyc(FILT - 1); sda_h = 1'b1;
      glitch_next = 0;
      wcyc(HP / 2 - HP / 4 - (FILT - 1));
    end else wcyc(HP / 2);
    rb = sda_line;
    wcyc(HP - HP / 2); scl_h = 1'b0;
  endtask

  task automatic t_wbyte(input logic [7:0] d, output logic ack);
    logic rb;
    for (int i = 7; i >= 0; i--) t_bit(d[i], rb);
    t_bit(1'b1, rb);
    ack = ~rb;
  endtask

  task automatic t_rbyte(input logic host_ack, output logic [7:0] d);
    logic rb;
    for (int i = 7; i >= 0; i--) begin t_bit(1'b1, rb); d[i] = rb; end
    t_bit(~host_ack, rb);
  endtask

  task automatic hw_write(input logic [6:0] adr, input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    t_start(); t_wbyte({adr, 1'b0}, a1); t_wbyte(p, a2); t_wbyte(d, a3); t_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic hw_setptr(input logic [7:0] p, output logic ok);
    logic a1, a2;
    t_start(); t_wbyte(8'h90, a1); t_wbyte(p, a2); t_stop();
    ok = a1 & a2;
  endtask

  task automatic hw_read(output logic [7:0] d, output logic ok);
    t_start(); t_wbyte(8'h91, ok); t_rbyte(1'b0, d); t_stop();
  endtask

  task automatic hw_read_rs(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    t_start(); t_wbyte(8'h90, a1); t_wbyte(p, a2);
    t_start(); t_wbyte(8'h91, a3); t_rbyte(1'b0, d); t_stop();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    report();
    $finish;
  end

  initial begin
    logic ok, rb;
    logic [7:0] d;
    int w0, o0;
    void'($urandom(32'h1C2A_0048));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i[7:0]);
    rst_n = 1'b0; en_n = 1'b1; scl_h = 1'b1; sda_h = 1'b1;
    wcyc(10);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(reg_wr_stb == 1'b0, "R1 wr_stb", reg_wr_stb, 0);
    chk(reg_ptr == 8'h00, "R1 ptr", reg_ptr, 0);
    rst_n = 1'b1; en_n = 1'b0;
    wcyc(20);

    // R4 full write
    w0 = wr_cnt;
    hw_write(7'h48, 8'h10, 8'hA5, ok);
    exp_mem[8'h10] = 8'hA5;
    chk(ok, "R4 acks", ok, 1);
    chk(wr_cnt == w0 + 1, "R4 write count", wr_cnt - w0, 1);
    chk(last_wr_ptr == 8'h10 && last_wr_data == 8'hA5, "R4 ptr/data", {last_wr_ptr, last_wr_data}, 16'h10A5);
    // R11 hold after SCL fall
    chk(last_gap >= HOLD && last_gap <= HOLD + 12, "R11 hold gap", last_gap, HOLD);

    // R5 pointer set then read
    hw_setptr(8'h10, ok);
    hw_read(d, rb);
    chk(ok && rb && d == exp_mem[8'h10], "R5 read after pointer set", d, exp_mem[8'h10]);

    // R6 repeated start read
    hw_read_rs(8'h22, d, ok);
    chk(ok && d == exp_mem[8'h22], "R6 repeated start read", d, exp_mem[8'h22]);

    // R2 foreign address
    w0 = wr_cnt; o0 = oe_cnt;
    hw_write(7'h4A, 8'h10, 8'h11, ok);
    chk(!ok, "R2 foreign address ack", ok, 0);
    chk(wr_cnt == w0 && oe_cnt == o0, "R2 no write/drive", oe_cnt - o0 + wr_cnt - w0, 0);

    // R3 disabled
    en_n = 1'b1; wcyc(10);
    w0 = wr_cnt; o0 = oe_cnt;
    hw_write(7'h48, 8'h10, 8'h3C, ok);
    chk(!ok && wr_cnt == w0 && oe_cnt == o0, "R3 disabled quiet", oe_cnt - o0 + wr_cnt - w0, 0);
    en_n = 1'b0; wcyc(10);
    hw_read_rs(8'h10, d, ok);
    chk(d == 8'hA5, "R3 register kept", d, 8'hA5);

    // R7 NACK ends read
    hw_setptr(8'h33, ok);
    t_start(); t_wbyte(8'h91, ok); t_rbyte(1'b0, d);
    chk(d == exp_mem[8'h33], "R7 read data", d, exp_mem[8'h33]);
    wcyc(HOLD + 20);
    o0 = oe_cnt;
    for (int i = 0; i < 9; i++) t_bit(1'b1, rb);
    chk(oe_cnt == o0, "R7 released after NACK", oe_cnt - o0, 0);
    t_stop();

    // R8 STOP mid-byte
    w0 = wr_cnt;
    t_start(); t_wbyte(8'h90, ok); t_wbyte(8'h30, ok);
    for (int i = 0; i < 4; i++) t_bit(1'b0, rb);
    t_stop();
    chk(wr_cnt == w0, "R8 stop abort no write", wr_cnt - w0, 0);
    // R8 START mid-byte then read
    t_start(); t_wbyte(8'h90, ok); t_wbyte(8'h31, ok);
    for (int i = 0; i < 3; i++) t_bit(1'b1, rb);
    t_start(); t_wbyte(8'h91, ok); t_rbyte(1'b0, d); t_stop();
    chk(ok && wr_cnt == w0 && d == exp_mem[8'h31], "R8 start abort read", d, exp_mem[8'h31]);

    // R10 glitch inside address bit
    w0 = wr_cnt;
    glitch_next = 1;
    hw_write(7'h48, 8'h40, 8'h5A, ok);
    exp_mem[8'h40] = 8'h5A;
    chk(ok && wr_cnt == w0 + 1 && last_wr_data == 8'h5A, "R10 glitch ignored", last_wr_data, 8'h5A);

    // R9 timeout during acknowledge
    t_start();
    for (int i = 7; i >= 0; i--) t_bit(((8'h90 >> i) & 1) != 0, rb);
    wcyc(HOLD + 20);
    chk(sda_oe == 1'b1, "R9 ack driven", sda_oe, 1);
    wcyc(TMO / 2);
    chk(sda_oe == 1'b1, "R9 not early", sda_oe, 1);
    wcyc(TMO);
    chk(sda_oe == 1'b0, "R9 released", sda_oe, 0);
    hw_write(7'h48, 8'h50, 8'hC3, ok);
    exp_mem[8'h50] = 8'hC3;
    chk(ok && last_wr_ptr == 8'h50, "R9 recovers", last_wr_ptr, 8'h50);

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [7:0] p, v;
      int op;
      op = int'($urandom % 3);
      p = 8'($urandom);
      v = 8'($urandom);
      if (op == 0) begin
        w0 = wr_cnt;
        hw_write(7'h48, p, v, ok);
        exp_mem[p] = v;
        chk(ok && wr_cnt == w0 + 1 && last_wr_ptr == p && last_wr_data == v, "R4 random write", {last_wr_ptr, last_wr_data}, {p, v});
      end else if (op == 1) begin
        hw_setptr(p, ok);
        hw_read(d, rb);
        chk(ok && rb && d == exp_mem[p], "R5 random read", d, exp_mem[p]);
      end else begin
        hw_read_rs(p, d, ok);
        chk(ok && d == exp_mem[p], "R6 random read", d, exp_mem[p]);
      end
    end

    report();
    $finish;
  end
endmodule